// File: doc/BRIEF.md
# Eight-Channel Priority Byte Mover

This block copies bytes between a wide memory-side bus (a 16-bit pointer plus an 8-bit bank, 24 address bits in all) and a narrow peripheral-side bus with an 8-bit port number. It has eight channels. Each channel keeps its own settings: a control byte, a peripheral base port, a memory pointer and bank, and a 16-bit byte count. A host programs these settings through a byte-wide register port. It then writes a launch mask that marks channels as pending.

Every cycle in which `service` is high and some channel is pending is a slot. In each slot the engine moves exactly one byte for the lowest-numbered pending channel. The byte goes from one bus to the other within that same cycle. After each byte the engine steps the channel's pointer, count and port-offset index. When the count runs out, the channel retires and the engine raises a one-cycle completion pulse for it.

The peripheral port for each byte is the base port plus a small offset. The offset comes from a short repeating pattern that the channel's mode selects. This lets one channel feed register pairs or register quads.

Top module: `prio_dma_top`

## Requirements
- R1: After reset, every channel reads back as all ones in every register, so the mode is 7, all control flags are set, and the pointer, count and table fields are 0xFFFF. No channel is pending, `busy` is 0 and `chan_done` is 0.
- R2: The register port selects the channel with `reg_addr[6:4]` and the field with `reg_addr[3:0]`. The fields are: 0 control, 1 base port, 2 and 3 pointer low and high, 4 bank, 5 and 6 count low and high, 7 indirect bank, 8 and 9 table pointer low and high, A line counter. Offsets B and F are two names for one spare byte. Reads return the stored value with `reg_hit`=1. Offsets C, D and E store nothing and read 0 with `reg_hit`=0.
- R3: A write to the launch port sets each channel's pending flag to the matching bit of `start_mask` and clears the flags whose bit is 0. `busy` is high exactly while any channel is pending.
- R4: In each slot only the lowest-numbered pending channel is served. A higher-numbered channel waits until every lower one has retired.
- R5: The peripheral port is the base port plus an offset chosen by the mode (control bits 2:0), indexed by the channel's 2-bit index. The patterns are: modes 0, 2 and 6 give 0 every time; modes 1 and 5 give 0,1; modes 3 and 7 give 0,0,1,1; mode 4 gives 0,1,2,3.
- R6: The offset index advances by one after every byte, wraps modulo 4, and returns to 0 when the channel retires.
- R7: After each byte the memory pointer stays the same if control bit 3 (fixed) is 1. Otherwise it moves down by one if control bit 4 is 1, or up by one if bit 4 is 0, wrapping within 16 bits. The bank never changes.
- R8: The count drops by one per byte, and the channel retires on the byte that takes the count to zero. A count of 0 at launch moves 65536 bytes.
- R9: With control bit 7 = 0, a slot raises `a_rd` and `b_wr` and drives `b_wdata` from `a_rdata`. With bit 7 = 1, it raises `b_rd` and `a_wr` and drives `a_wdata` from `b_rdata`.
- R10: `chan_done[i]` is high for exactly the one cycle after the slot that carried channel i's last byte.
- R11: No bus strobe is raised, and no channel state changes, when `service` is low, when no channel is pending, or when the launch port is written in the same cycle (that slot is skipped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Register port address: channel in 6:4, field in 3:0 |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 8 | Register read data (combinational) |
| reg_hit | output | 1 | The read address maps to a stored field |
| start_we | input | 1 | Launch port write strobe |
| start_mask | input | 8 | Launch mask, one bit per channel |
| service | input | 1 | Slot strobe: at most one byte per cycle |
| a_addr | output | 24 | Memory bus address {bank, pointer} |
| a_rd | output | 1 | Memory bus read strobe |
| a_wr | output | 1 | Memory bus write strobe |
| a_wdata | output | 8 | Memory bus write data |
| a_rdata | input | 8 | Memory bus read data |
| b_addr | output | 8 | Peripheral bus port number |
| b_rd | output | 1 | Peripheral bus read strobe |
| b_wr | output | 1 | Peripheral bus write strobe |
| b_wdata | output | 8 | Peripheral bus write data |
| b_rdata | input | 8 | Peripheral bus read data |
| busy | output | 1 | Some channel is pending |
| chan_done | output | 8 | One-cycle completion pulse per channel |

## Verification
The assertions check several invariants on every cycle: at most one channel is granted, no strobe is raised while idle, and the two directions never mix. Every served byte must step the pointer and count correctly, advance the index, and leave a channel that reports completion no longer pending. Only the bench scenarios can show the things that depend on programmed values. These are the exact port offset pattern of each mode, priority handover between channels, and the register map with its alias and unmapped offsets. They also include the index restarting from zero on a relaunch and a zero count running for a full 65536 bytes.

// File: rtl/prio_dma_pkg.sv
package prio_dma_pkg;

    typedef struct packed {
        logic       dir;      // 1: peripheral -> memory
        logic       indir;    // stored only
        logic       spare;    // stored only
        logic       dec;      // pointer moves down
        logic       fixed;    // pointer held
        logic [2:0] mode;     // offset pattern select
    } ctrl_t;

    typedef struct packed {
        ctrl_t       ctrl;
        logic [7:0]  b_base;
        logic [15:0] a_ptr;
        logic [7:0]  a_bank;
        logic [15:0] count;
        logic [7:0]  ind_bank;
        logic [15:0] tbl_ptr;
        logic [7:0]  line_cnt;
        logic [7:0]  spare_byte;
    } chan_regs_t;

    localparam logic [3:0] FLD_CTRL   = 4'h0;
    localparam logic [3:0] FLD_BBASE  = 4'h1;
    localparam logic [3:0] FLD_PTR_L  = 4'h2;
    localparam logic [3:0] FLD_PTR_H  = 4'h3;
    localparam logic [3:0] FLD_BANK   = 4'h4;
    localparam logic [3:0] FLD_CNT_L  = 4'h5;
    localparam logic [3:0] FLD_CNT_H  = 4'h6;
    localparam logic [3:0] FLD_IBANK  = 4'h7;
    localparam logic [3:0] FLD_TBL_L  = 4'h8;
    localparam logic [3:0] FLD_TBL_H  = 4'h9;
    localparam logic [3:0] FLD_LINE   = 4'hA;
    localparam logic [3:0] FLD_SPARE0 = 4'hB;
    localparam logic [3:0] FLD_SPARE1 = 4'hF;

    // Port offset for a given mode and position in the repeating pattern.
    function automatic logic [1:0] port_offset(input logic [2:0] mode, input logic [1:0] idx);
        case (mode)
            3'd1, 3'd5: port_offset = {1'b0, idx[0]};
            3'd3, 3'd7: port_offset = {1'b0, idx[1]};
            3'd4:       port_offset = idx;
            default:    port_offset = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/prio_dma_arb.sv
module prio_dma_arb #(
    parameter int N_CHAN = 8,
    localparam int IDX_W = $clog2(N_CHAN)
) (
    input  logic [N_CHAN-1:0] req,
    output logic [N_CHAN-1:0] grant,
    output logic [IDX_W-1:0]  grant_idx
);
    // Fixed priority: lowest index wins, so scan from the top down.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        for (int i = N_CHAN - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_dma_chan.sv
module prio_dma_chan
    import prio_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_off,
    input  logic [7:0] wr_data,
    input  logic       start_we,
    input  logic       start_bit,
    input  logic       step,
    output chan_regs_t regs_o,
    output logic       active_o,
    output logic [1:0] idx_o,
    output logic       done_o
);
    typedef struct packed {
        chan_regs_t regs;
        logic       active;
        logic [1:0] idx;
        logic       done;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (step) begin
            if (!st_q.regs.ctrl.fixed) begin
                st_d.regs.a_ptr = st_q.regs.ctrl.dec ? st_q.regs.a_ptr - 16'd1
                                                     : st_q.regs.a_ptr + 16'd1;
            end
            st_d.regs.count = st_q.regs.count - 16'd1;
            st_d.idx        = st_q.idx + 2'd1;
            if (st_q.regs.count == 16'd1) begin
                st_d.active = 1'b0;
                st_d.idx    = 2'd0;
                st_d.done   = 1'b1;
            end
        end
        if (start_we) begin
            st_d.active = start_bit;
        end
        if (wr_en) begin
            case (wr_off)
                FLD_CTRL:  st_d.regs.ctrl             = ctrl_t'(wr_data);
                FLD_BBASE: st_d.regs.b_base           = wr_data;
                FLD_PTR_L: st_d.regs.a_ptr[7:0]       = wr_data;
                FLD_PTR_H: st_d.regs.a_ptr[15:8]      = wr_data;
                FLD_BANK:  st_d.regs.a_bank           = wr_data;
                FLD_CNT_L: st_d.regs.count[7:0]       = wr_data;
                FLD_CNT_H: st_d.regs.count[15:8]      = wr_data;
                FLD_IBANK: st_d.regs.ind_bank         = wr_data;
                FLD_TBL_L: st_d.regs.tbl_ptr[7:0]     = wr_data;
                FLD_TBL_H: st_d.regs.tbl_ptr[15:8]    = wr_data;
                FLD_LINE:  st_d.regs.line_cnt         = wr_data;
                FLD_SPARE0,
                FLD_SPARE1: st_d.regs.spare_byte      = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.regs   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o   = st_q.regs;
    assign active_o = st_q.active;
    assign idx_o    = st_q.idx;
    assign done_o   = st_q.done;

    // R7: pointer stepping
    a_r7_ptr_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && !st_q.regs.ctrl.fixed && !st_q.regs.ctrl.dec)
        |=> st_q.regs.a_ptr == $past(st_q.regs.a_ptr) + 16'd1);
    a_r7_ptr_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && !st_q.regs.ctrl.fixed && st_q.regs.ctrl.dec)
        |=> st_q.regs.a_ptr == $past(st_q.regs.a_ptr) - 16'd1);
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && st_q.regs.ctrl.fixed) |=> $stable(st_q.regs.a_ptr));
    // R8: count decrements once per byte
    a_r8_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en) |=> st_q.regs.count == $past(st_q.regs.count) - 16'd1);
    // R6: index advances mid-run and is cleared on retirement
    a_r6_idx_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.regs.count != 16'd1) |=> st_q.idx == $past(st_q.idx) + 2'd1);
    a_r6_idx_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.regs.count == 16'd1 && !start_we) |=> (st_q.idx == 2'd0 && !st_q.active));
    // R10: a completion pulse means the channel is no longer pending
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.active);
    // R11: a step only happens on a pending channel
    a_r11_step_pending: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> st_q.active);
endmodule

// File: rtl/prio_dma_top.sv
module prio_dma_top
    import prio_dma_pkg::*;
#(
    parameter int N_CHAN = 8,
    localparam int CH_W = $clog2(N_CHAN),
    localparam int RA_W = CH_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    output logic              reg_hit,
    input  logic              start_we,
    input  logic [N_CHAN-1:0] start_mask,
    input  logic              service,
    output logic [23:0]       a_addr,
    output logic              a_rd,
    output logic              a_wr,
    output logic [7:0]        a_wdata,
    input  logic [7:0]        a_rdata,
    output logic [7:0]        b_addr,
    output logic              b_rd,
    output logic              b_wr,
    output logic [7:0]        b_wdata,
    input  logic [7:0]        b_rdata,
    output logic              busy,
    output logic [N_CHAN-1:0] chan_done
);
    chan_regs_t        regs [N_CHAN];
    logic [1:0]        idxs [N_CHAN];
    logic [N_CHAN-1:0] active;
    logic [N_CHAN-1:0] grant;
    logic [N_CHAN-1:0] step;
    logic [CH_W-1:0]   gidx;
    logic [CH_W-1:0]   rd_ch;
    logic              slot;
    chan_regs_t        sel;
    chan_regs_t        rsel;

    assign busy  = |active;
    assign slot  = service && busy && !start_we;
    assign step  = grant & {N_CHAN{slot}};
    assign rd_ch = reg_addr[RA_W-1:4];

    prio_dma_arb #(.N_CHAN(N_CHAN)) arb_i (
        .req       (active),
        .grant     (grant),
        .grant_idx (gidx)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        prio_dma_chan chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_we && (rd_ch == CH_W'(c))),
            .wr_off    (reg_addr[3:0]),
            .wr_data   (reg_wdata),
            .start_we  (start_we),
            .start_bit (start_mask[c]),
            .step      (step[c]),
            .regs_o    (regs[c]),
            .active_o  (active[c]),
            .idx_o     (idxs[c]),
            .done_o    (chan_done[c])
        );
    end

    // Bus side: one byte per slot, moved within the same cycle.
    always_comb begin
        sel     = regs[gidx];
        a_addr  = {sel.a_bank, sel.a_ptr};
        b_addr  = sel.b_base + {6'd0, port_offset(sel.ctrl.mode, idxs[gidx])};
        a_rd    = slot && !sel.ctrl.dir;
        b_wr    = slot && !sel.ctrl.dir;
        b_rd    = slot &&  sel.ctrl.dir;
        a_wr    = slot &&  sel.ctrl.dir;
        b_wdata = a_rd ? a_rdata : 8'd0;
        a_wdata = a_wr ? b_rdata : 8'd0;
    end

    // Register read port.
    always_comb begin
        rsel      = regs[rd_ch];
        reg_hit   = 1'b1;
        reg_rdata = 8'd0;
        case (reg_addr[3:0])
            FLD_CTRL:   reg_rdata = rsel.ctrl;
            FLD_BBASE:  reg_rdata = rsel.b_base;
            FLD_PTR_L:  reg_rdata = rsel.a_ptr[7:0];
            FLD_PTR_H:  reg_rdata = rsel.a_ptr[15:8];
            FLD_BANK:   reg_rdata = rsel.a_bank;
            FLD_CNT_L:  reg_rdata = rsel.count[7:0];
            FLD_CNT_H:  reg_rdata = rsel.count[15:8];
            FLD_IBANK:  reg_rdata = rsel.ind_bank;
            FLD_TBL_L:  reg_rdata = rsel.tbl_ptr[7:0];
            FLD_TBL_H:  reg_rdata = rsel.tbl_ptr[15:8];
            FLD_LINE:   reg_rdata = rsel.line_cnt;
            FLD_SPARE0,
            FLD_SPARE1: reg_rdata = rsel.spare_byte;
            default:    reg_hit   = 1'b0;
        endcase
    end

    // R4: never more than one channel granted
    a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step));
    // R4: a served channel has no pending lower-numbered neighbour
    a_r4_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        ((step & active) != '0) |-> (((step - 1'b1) & active) == '0));
    // R11: nothing on the buses when idle
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || !service || start_we) |-> !(a_rd || a_wr || b_rd || b_wr));
    // R9: directions never mix
    a_r9_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !((a_rd || b_wr) && (a_wr || b_rd)));
    // R3: busy follows the launch mask
    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        start_we |=> (busy == (|$past(start_mask))));
endmodule

// File: tb/prio_dma_top_tb.sv
module prio_dma_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic        reg_hit;
    logic        start_we = 1'b0;
    logic [7:0]  start_mask = '0;
    logic        service = 1'b0;
    logic [23:0] a_addr;
    logic        a_rd, a_wr, b_rd, b_wr;
    logic [7:0]  a_wdata, b_wdata, b_addr;
    logic [7:0]  a_rdata = '0;
    logic [7:0]  b_rdata = '0;
    logic        busy;
    logic [7:0]  chan_done;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    prio_dma_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .reg_hit(reg_hit),
        .start_we(start_we), .start_mask(start_mask), .service(service),
        .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .busy(busy), .chan_done(chan_done)
    );

    // {addr[6:0], write data, expected read, expected hit}
    localparam logic [23:0] VEC [14] = '{
        {7'h00, 8'h5A, 8'h5A, 1'b1},
        {7'h11, 8'h34, 8'h34, 1'b1},
        {7'h22, 8'h78, 8'h78, 1'b1},
        {7'h23, 8'h12, 8'h12, 1'b1},
        {7'h34, 8'hC3, 8'hC3, 1'b1},
        {7'h45, 8'h01, 8'h01, 1'b1},
        {7'h46, 8'h80, 8'h80, 1'b1},
        {7'h57, 8'h66, 8'h66, 1'b1},
        {7'h68, 8'h11, 8'h11, 1'b1},
        {7'h69, 8'h22, 8'h22, 1'b1},
        {7'h7A, 8'h99, 8'h99, 1'b1},
        {7'h7B, 8'h44, 8'h44, 1'b1},
        {7'h7C, 8'h55, 8'h00, 1'b0},
        {7'h7E, 8'h77, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [7:0] exp, input logic hit);
        reg_addr = a;
        #1;
        chk(req, "read data", reg_rdata, exp);
        chk(req, "read hit", reg_hit, hit);
    endtask

    task automatic launch(input logic [7:0] m);
        @(negedge clk);
        start_we = 1'b1; start_mask = m;
        @(negedge clk);
        start_we = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [7:0] ctrl, input logic [7:0] bb,
                        input logic [15:0] ptr, input logic [7:0] bank, input logic [15:0] cnt);
        logic [6:0] base;
        base = 7'(ch << 4);
        wr(base | 7'h0, ctrl);
        wr(base | 7'h1, bb);
        wr(base | 7'h2, ptr[7:0]);
        wr(base | 7'h3, ptr[15:8]);
        wr(base | 7'h4, bank);
        wr(base | 7'h5, cnt[7:0]);
        wr(base | 7'h6, cnt[15:8]);
    endtask

    // One service slot: checks the same-cycle bus picture.
    task automatic slot(input string req, input logic dir, input logic [23:0] ea, input logic [7:0] eb);
        @(negedge clk);
        service = 1'b1;
        a_rdata = ea[7:0] ^ 8'hA5;
        b_rdata = eb ^ 8'h3C;
        #1;
        chk(req, "a_addr", a_addr, ea);
        chk(req, "b_addr", b_addr, eb);
        chk("R10", "done low during run", chan_done, 8'h00);
        if (!dir) begin
            chk("R9", "a_rd/b_wr/a_wr/b_rd", {a_rd, b_wr, a_wr, b_rd}, 4'b1100);
            chk("R9", "b_wdata", b_wdata, ea[7:0] ^ 8'hA5);
        end else begin
            chk("R9", "a_rd/b_wr/a_wr/b_rd", {a_rd, b_wr, a_wr, b_rd}, 4'b0011);
            chk("R9", "a_wdata", a_wdata, eb ^ 8'h3C);
        end
        @(negedge clk);
        service = 1'b0;
    endtask

    initial begin
        #1500000;
        fails++;
        tests++;
        $display("FAIL R11 watchdog: got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_chk("R1", 7'h30, 8'hFF, 1'b1);
        rd_chk("R1", 7'h32, 8'hFF, 1'b1);
        rd_chk("R1", 7'h36, 8'hFF, 1'b1);
        rd_chk("R1", 7'h79, 8'hFF, 1'b1);
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "chan_done", chan_done, 8'h00);

        // R2: register map walk
        foreach (VEC[k]) begin
            wr(VEC[k][23:17], VEC[k][16:9]);
            rd_chk("R2", VEC[k][23:17], VEC[k][8:1], VEC[k][0]);
        end
        rd_chk("R2", 7'h7F, 8'h44, 1'b1);   // alias of offset B
        rd_chk("R2", 7'h7D, 8'h00, 1'b0);

        // R4 R5 R7 R8: two channels, priority handover
        prog(1, 8'h04, 8'h10, 16'h1000, 8'h7E, 16'd5);
        prog(0, 8'h01, 8'h20, 16'h2000, 8'h01, 16'd2);
        launch(8'h03);
        chk("R3", "busy after launch", busy, 1'b1);
        slot("R4", 1'b0, 24'h012000, 8'h20);
        slot("R5", 1'b0, 24'h012001, 8'h21);
        chk("R10", "ch0 done pulse", chan_done, 8'h01);
        slot("R4", 1'b0, 24'h7E1000, 8'h10);
        slot("R5", 1'b0, 24'h7E1001, 8'h11);
        slot("R5", 1'b0, 24'h7E1002, 8'h12);
        slot("R5", 1'b0, 24'h7E1003, 8'h13);
        slot("R6", 1'b0, 24'h7E1004, 8'h10);
        chk("R10", "ch1 done pulse", chan_done, 8'h02);
        chk("R8", "busy after finish", busy, 1'b0);
        rd_chk("R8", 7'h15, 8'h00, 1'b1);
        rd_chk("R7", 7'h12, 8'h05, 1'b1);
        rd_chk("R7", 7'h14, 8'h7E, 1'b1);

        // R6: index restarts at 0 after retirement
        wr(7'h15, 8'd1);
        launch(8'h02);
        slot("R6", 1'b0, 24'h7E1005, 8'h10);

        // R7 R9: decrement, peripheral -> memory, mode 3
        prog(2, 8'h93, 8'h40, 16'h3000, 8'h05, 16'd4);
        launch(8'h04);
        slot("R7", 1'b1, 24'h053000, 8'h40);
        slot("R5", 1'b1, 24'h052FFF, 8'h40);
        slot("R5", 1'b1, 24'h052FFE, 8'h41);
        slot("R5", 1'b1, 24'h052FFD, 8'h41);
        // R7: fixed pointer, mode 2
        prog(3, 8'h8A, 8'h50, 16'h4000, 8'h09, 16'd2);
        launch(8'h08);
        slot("R7", 1'b1, 24'h094000, 8'h50);
        slot("R7", 1'b1, 24'h094000, 8'h50);
        // R5: mode 7 behaves like mode 3
        prog(4, 8'h07, 8'h60, 16'h0100, 8'h00, 16'd4);
        launch(8'h10);
        slot("R5", 1'b0, 24'h000100, 8'h60);
        slot("R5", 1'b0, 24'h000101, 8'h60);
        slot("R5", 1'b0, 24'h000102, 8'h61);
        slot("R5", 1'b0, 24'h000103, 8'h61);

        // R11: launch in the same cycle as service skips the slot
        prog(5, 8'h00, 8'h70, 16'h0200, 8'h00, 16'd2);
        launch(8'h20);
        @(negedge clk);
        service = 1'b1; start_we = 1'b1; start_mask = 8'h20;
        #1;
        chk("R11", "no strobe on launch cycle", {a_rd, a_wr, b_rd, b_wr}, 4'b0000);
        @(negedge clk);
        service = 1'b0; start_we = 1'b0;
        rd_chk("R11", 7'h55, 8'h02, 1'b1);
        // R3: clearing the mask stops the channel
        launch(8'h00);
        chk("R3", "busy after empty mask", busy, 1'b0);
        @(negedge clk);
        service = 1'b1;
        #1;
        chk("R11", "no strobe when idle", {a_rd, a_wr, b_rd, b_wr}, 4'b0000);
        @(negedge clk);
        service = 1'b0;
        rd_chk("R11", 7'h52, 8'h00, 1'b1);

        // R8: count 0 moves 65536 bytes
        prog(6, 8'h00, 8'h80, 16'hFFFE, 8'h00, 16'd0);
        launch(8'h40);
        @(negedge clk);
        service = 1'b1;
        repeat (65535) @(negedge clk);
        #1;
        chk("R8", "still busy after 65535", busy, 1'b1);
        chk("R8", "pointer after 65535", a_addr, 24'h00FFFD);
        @(negedge clk);
        service = 1'b0;
        chk("R8", "busy after 65536", busy, 1'b0);
        chk("R10", "ch6 done pulse", chan_done, 8'h40);
        @(negedge clk);
        chk("R10", "pulse lasts one cycle", chan_done, 8'h00);
        rd_chk("R7", 7'h62, 8'hFE, 1'b1);
        rd_chk("R7", 7'h63, 8'hFF, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule